// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the bit-rate enable pulses for a serial transmitter and receiver from a fast system clock. Instead of dividing the clock by an integer, it adds a 32-bit tuning word to a phase accumulator on every clock. Each time the accumulator wraps past its top, the block raises a one-cycle baud tick. The tuning word is the ratio of baud rate to clock frequency, scaled by 2^32 and truncated to an integer. Ratios that do not divide evenly therefore come out right on average, with one clock of jitter.

A second accumulator runs alongside the first. Its step is the same word multiplied by 16, which gives the 16x oversampling pulse that a receiver needs. When that product would not fit in 32 bits, the step is clamped to all ones.

Software changes the rate at run time by writing a new word through a one-cycle write strobe. The new word is used from the next clock onward. The accumulators keep their phase across the change, so no pulse is lost or doubled at the switch. Reset clears both accumulators and loads the word for 115200 baud from a 100 MHz clock, which is 0x004B7F5A (4947802).

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, both ticks are low. Leaving reset, the active word is 4947802 (115200 baud at 100 MHz) and both accumulators start from zero.
- R2: `baud_tick` is a single-cycle pulse. With any word below 2^31 it is never high in two consecutive cycles.
- R3: Let S be the sum of the baud steps added since reset. Each clock adds the word that was active before that edge. The number of `baud_tick` cycles seen after a clock edge equals floor(S / 2^32).
- R4: `os_tick` obeys the R3 counting rule with a step of word × 16 whenever that product is below 2^32.
- R5: When word × 16 is 2^32 or more, the oversample step is 0xFFFFFFFF.
- R6: A write with `wr_en` high loads `wr_data` at that clock edge. The new word is added from the following edge onward. The accumulators are not cleared, so the R3 and R4 counts stay exact across any number of writes.
- R7: With a word of 0 loaded, the accumulators stop advancing and neither tick occurs.
- R8: With a word of 2^30, `baud_tick` pulses exactly every 4 cycles.
- R9: The baud tick and the oversample tick are independent. Both may be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the tuning word |
| wr_data | input | 32 | New tuning word |
| baud_tick | output | 1 | One-cycle pulse at the bit rate |
| os_tick | output | 1 | One-cycle pulse at 16x the bit rate |

## Verification
Two events can fall in the same cycle. The first is a baud tick and an oversample tick together. With a word of 2^31, the oversample step saturates, so nearly every cycle carries an oversample pulse while every other cycle carries a baud pulse. The bench counts the cycles in which both are high and requires that count to be non-zero, and it still checks each count against its own phase sum. The second is a tuning-word write on a clock edge where an accumulator wraps. The rate-switch scenario writes several words at arbitrary points. The bench keeps a 64-bit running phase total, adding the word that was active before each edge, and compares both pulse counts with that total divided by 2^32 after every segment.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
  localparam int unsigned ACC_W = 32;
  localparam int unsigned NUM_RATES = 2;  // 0: bit rate, 1: oversampled

  typedef logic [ACC_W-1:0] phase_t;

  // word = floor(baud * 2^ACC_W / clk_hz)
  function automatic phase_t tuning_for(input longint unsigned baud,
                                        input longint unsigned clk_hz);
    longint unsigned scaled;
    scaled = (baud << ACC_W) / clk_hz;
    return phase_t'(scaled);
  endfunction

  // word << sh, clamped to all ones when high bits would be lost
  function automatic phase_t scale_sat(input phase_t w, input int unsigned sh);
    phase_t top_bits;
    top_bits = w >> (ACC_W - sh);
    if (top_bits != '0) return '1;
    return w << sh;
  endfunction
endpackage

// File: rtl/baud_word_reg.sv
`timescale 1ns/1ps
module baud_word_reg
  import baud_pkg::*;
#(
  parameter phase_t RESET_WORD = phase_t'(4947802)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  phase_t wr_data,
  output phase_t word
);
  phase_t word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     word_q <= RESET_WORD;
    else if (wr_en) word_q <= wr_data;
  end

  assign word = word_q;

  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> word_q == $past(wr_data)); // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word_q)); // R6
endmodule

// File: rtl/baud_phase_acc.sv
`timescale 1ns/1ps
module baud_phase_acc
  import baud_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t step,
  output logic   tick
);
  phase_t           acc_q;
  logic             tick_q;
  logic [ACC_W:0]   sum;
  logic             carry_evt;  // wrap event, brought out for the checks

  assign sum       = {1'b0, acc_q} + {1'b0, step};
  assign carry_evt = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= carry_evt;
    end
  end

  assign tick = tick_q;

  AST_WRAP_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> acc_q < $past(step)); // R3
  AST_NO_WRAP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_q |-> acc_q >= $past(acc_q)); // R3
  AST_ZERO_STEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) == '0) |-> !tick_q); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !step[ACC_W-1] && $stable(step)) |=> !tick_q); // R2
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 100_000_000,
  parameter longint unsigned RESET_BAUD = 115_200,
  parameter int unsigned     OS_SHIFT   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        baud_tick,
  output logic        os_tick
);
  localparam phase_t RESET_WORD = tuning_for(RESET_BAUD, CLK_HZ);

  phase_t word_q;
  phase_t steps [NUM_RATES];
  logic   ticks [NUM_RATES];

  baud_word_reg #(.RESET_WORD(RESET_WORD)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(phase_t'(wr_data)),
    .word   (word_q)
  );

  assign steps[0] = word_q;
  assign steps[1] = scale_sat(word_q, OS_SHIFT);

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    baud_phase_acc u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .step (steps[g]),
      .tick (ticks[g])
    );
  end

  assign baud_tick = ticks[0];
  assign os_tick   = ticks[1];

  AST_OS_NOT_SLOWER: assert property (@(posedge clk) disable iff (!rst_n)
    steps[1] >= steps[0]); // R4
  AST_OS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q[ACC_W-1 -: OS_SHIFT] != '0) |-> (&steps[1])); // R5
endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        baud_tick, os_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model state: total phase per rate, counts, gap tracking
  logic [63:0] ph_b, ph_o;
  logic [31:0] cur_w;
  longint cnt_b, cnt_o, cnt_both, b2b, cyc, last_b, bad_gap;
  bit prev_b;
  longint want_gap;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .os_tick(os_tick)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] os_of(input logic [31:0] w);
    logic [35:0] wide;
    wide = {4'b0, w} * 36'd16;
    if (wide > 36'hFFFF_FFFF) return 32'hFFFF_FFFF;
    return wide[31:0];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: optional write presented before the edge, outputs sampled at negedge
  task automatic step_cycle(input bit do_wr, input logic [31:0] w);
    wr_en = do_wr;
    wr_data = w;
    @(posedge clk);
    ph_b += {32'b0, cur_w};
    ph_o += {32'b0, os_of(cur_w)};
    if (do_wr) cur_w = w;
    @(negedge clk);
    wr_en = 1'b0;
    cyc++;
    if (baud_tick) begin
      cnt_b++;
      if (prev_b) b2b++;
      if (want_gap != 0 && last_b >= 0 && (cyc - last_b) != want_gap) bad_gap++;
      last_b = cyc;
    end
    if (os_tick) cnt_o++;
    if (baud_tick && os_tick) cnt_both++;
    prev_b = baud_tick;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ph_b = '0; ph_o = '0; cur_w = 32'd4947802;
    cnt_b = 0; cnt_o = 0; cnt_both = 0; b2b = 0; cyc = 0;
    last_b = -1; bad_gap = 0; prev_b = 1'b0; want_gap = 0;
  endtask

  task automatic run(input logic [31:0] w, input bit do_wr, input int n);
    step_cycle(do_wr, w);
    for (int k = 1; k < n; k++) step_cycle(1'b0, '0);
  endtask

  task automatic check_counts(input string tag);
    check({tag, " baud count R3"}, cnt_b, longint'(ph_b >> 32));
    check({tag, " os count R4"}, cnt_o, longint'(ph_o >> 32));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R1 baud low in reset", baud_tick, 0);
      check("R1 os low in reset", os_tick, 0);
    end
  endtask

  task automatic t_default();
    do_reset();
    run('0, 1'b0, 40000);
    check("R1 default word 115200 count", cnt_b, (40000 * 64'd4947802) >> 32);
    check_counts("default");
    check("R2 no back-to-back", b2b, 0);
  endtask

  task automatic t_fractional();
    do_reset();
    run(32'd412316, 1'b1, 30000);
    check_counts("9600");
    check("R2 no back-to-back 9600", b2b, 0);
  endtask

  task automatic t_integer();
    do_reset();
    want_gap = 4;
    run(32'h4000_0000, 1'b1, 2000);
    check_counts("quarter");
    check("R8 gap of 4 cycles", bad_gap, 0);
    check("R8 tick count", cnt_b > 490 ? 1 : 0, 1);
  endtask

  task automatic t_zero();
    do_reset();
    run(32'd0, 1'b1, 5000);
    check("R7 no baud ticks", cnt_b, 0);
    check("R7 no os ticks", cnt_o, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    run(32'h3000_0000, 1'b1, 1000);
    check_counts("clamp R5");
    check("R5 os near every cycle", cnt_o >= 998 ? 1 : 0, 1);
  endtask

  task automatic t_switch();
    do_reset();
    run(32'h4000_0000, 1'b1, 37);
    run(32'h1234_5678, 1'b1, 513);
    check_counts("switch-a R6");
    run(32'd412316, 1'b1, 20001);
    run(32'h0765_4321, 1'b1, 3);
    run(32'd4947802, 1'b1, 9000);
    check_counts("switch-b R6");
  endtask

  task automatic t_coincide();
    do_reset();
    run(32'h8000_0000, 1'b1, 400);
    check_counts("overlap");
    check("R9 both ticks same cycle", cnt_both > 0 ? 1 : 0, 1);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default();
    t_fractional();
    t_integer();
    t_zero();
    t_saturate();
    t_switch();
    t_coincide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule